// File: doc/BRIEF.md
# Prescribed Serial Sequence Generator

This block is a shift-register generator that emits one of two fixed serial bit patterns over and over. On every accepted transfer the register moves one place toward its output end. The serial bit is taken from the last stage, and a combinational function of the stages is loaded into the first stage. A static mode input picks between two variants. The linear variant is a four-stage register with exclusive-OR feedback. It runs through a maximal-length pseudo-noise cycle of 15 bits. The nonlinear variant is a four-stage register with AND/OR/NOT feedback that produces a prescribed 7-bit cycle. Three stages would satisfy the length bound S ≤ 2^n − 1 for that cycle, but the window `111` occurs twice in it. A fourth stage is therefore needed so that no two register states coincide.

The serial bit leaves the block as a valid/ready stream. `out_valid` is high when the generator is enabled, out of reset and settled on the selected mode. A bit is consumed on a clock edge where both `out_valid` and `out_ready` are high. While `out_ready` is low the bit and the state are held unchanged, so a slow consumer never loses or skips a pattern bit. The parallel state is also exposed for observation.

A synchronous reset, or any change of the mode input, reloads the register with the first four bits of the selected pattern. The stream then restarts at the beginning of that pattern.

Top module: `seqgen_top`

## Requirements
- R1: While `rst` is high, `out_valid` is low. The edge that samples `rst` high loads `out_state` with the seed of the mode on `mode_nl`: 4'b1111 for linear (`mode_nl`=0) and 4'b1011 for nonlinear (`mode_nl`=1). As a result `out_bit` shows the first pattern bit.
- R2: In linear mode, the bits accepted from reset on are 111101011001000, repeated with period 15.
- R3: In nonlinear mode, the bits accepted after the seed load are 1011110, repeated with period 7. Every valid state is one of 1011, 0111, 1111, 1110, 1101, 1010 or 0101.
- R4: `out_bit` equals `out_state[3]`. On an accepted transfer, `out_state[3:1]` takes the previous `out_state[2:0]`.
- R5: On an accepted transfer, `out_state[0]` takes the feedback of the previous state s. In linear mode the feedback is s[3] XOR s[0]. In nonlinear mode it is NOT(s[3] AND s[0] AND (s[2] OR NOT s[1])).
- R6: While `en` is low, `out_valid` is low and `out_state` holds, unless a mode change reloads it. After `en` returns high, the stream continues from the bit where it stopped.
- R7: While `out_valid` is high and `out_ready` is low, `out_state` and `out_bit` hold.
- R8: In a cycle where `mode_nl` differs from its value at the previous edge, `out_valid` is low. The next edge loads the new mode's seed, whatever the state of `en`.
- R9: In linear mode the all-zero state never appears while `out_valid` is high. If it is ever present, the next edge reloads the linear seed.
- R10: In nonlinear mode, the seven states visited during one period are all distinct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Generator enable |
| mode_nl | input | 1 | 0 selects the linear 15-bit pattern, 1 the nonlinear 7-bit pattern |
| out_ready | input | 1 | Consumer accepts the serial bit |
| out_valid | output | 1 | Serial bit is offered |
| out_bit | output | 1 | Serial pattern bit (last stage) |
| out_state | output | 4 | Parallel register state, bit 3 is the output stage |

## Verification
The properties assume that `rst` is high at the first clock edge, and that `mode_nl`, `en` and `out_ready` settle between edges rather than on them. They allow every input to change in any cycle. The hold properties for an idle generator are qualified by the checker's own record of the previous mode, so a reload on a mode change does not count as a violation. The stimulus drives all inputs shortly after each rising edge. It switches modes both while the generator is enabled and while it is disabled. It also mixes stretches with `out_ready` low into running streams, so every property's antecedent is exercised.

// File: rtl/seqgen_pkg.sv
package seqgen_pkg;

  localparam int STAGES  = 4;
  localparam int LIN_LEN = 15;
  localparam int NL_LEN  = 7;

  // Patterns written left to right: the MSB is the first bit emitted.
  localparam logic [LIN_LEN-1:0] LIN_PATTERN = 15'b111101011001000;
  localparam logic [NL_LEN-1:0]  NL_PATTERN  = 7'b1011110;

  // Stages holding the first STAGES bits; the MSB stage is the output stage.
  localparam logic [STAGES-1:0] LIN_SEED = LIN_PATTERN[LIN_LEN-1 -: STAGES];
  localparam logic [STAGES-1:0] NL_SEED  = NL_PATTERN[NL_LEN-1 -: STAGES];

  // Exclusive-OR taps for the linear variant: output stage and first stage.
  localparam logic [STAGES-1:0] LIN_TAPS = 4'b1001;

  typedef enum logic {
    MODE_LIN = 1'b0,
    MODE_NL  = 1'b1
  } gen_mode_e;

endpackage

// File: rtl/seqgen_fb.sv
module seqgen_fb #(
  parameter int N = 4,
  parameter bit NONLINEAR = 1'b0,
  parameter logic [N-1:0] TAPS = '0
) (
  input  logic [N-1:0] state,
  output logic         fb
);

  generate
    if (NONLINEAR) begin : g_nl
      // Next pattern bit from the map of the seven used states,
      // unused states taken as don't-cares.
      always_comb fb = ~(state[N-1] & state[0] & (state[N-2] | ~state[N-3]));
    end else begin : g_lin
      always_comb fb = ^(state & TAPS);
    end
  endgenerate

endmodule

// File: rtl/seqgen_ctrl.sv
module seqgen_ctrl #(
  parameter int N = 4,
  parameter logic [N-1:0] SEED_LIN = '1,
  parameter logic [N-1:0] SEED_NL  = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         mode_nl,
  input  logic         out_ready,
  input  logic [N-1:0] state,
  output logic         load,
  output logic [N-1:0] seed,
  output logic         shift,
  output logic         valid
);

  logic mode_q;
  logic mode_diff;
  logic lockup;

  always_ff @(posedge clk) begin
    mode_q <= mode_nl;
  end

  always_comb begin
    mode_diff = (mode_nl != mode_q);
    lockup    = (mode_q == 1'b0) && (state == '0);
    seed      = mode_nl ? SEED_NL : SEED_LIN;
    load      = rst | mode_diff | lockup;
    valid     = en & ~rst & ~mode_diff & ~lockup;
    shift     = valid & out_ready;
  end

endmodule

// File: rtl/seqgen_shreg.sv
module seqgen_shreg #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         load,
  input  logic [N-1:0] seed,
  input  logic         shift,
  input  logic         fb,
  output logic [N-1:0] state
);

  always_ff @(posedge clk) begin
    if (load) begin
      state <= seed;
    end else if (shift) begin
      state <= {state[N-2:0], fb};
    end
  end

endmodule

// File: rtl/seqgen_top.sv
module seqgen_top
  import seqgen_pkg::*;
#(
  parameter int N_STAGES = STAGES
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                mode_nl,
  input  logic                out_ready,
  output logic                out_valid,
  output logic                out_bit,
  output logic [N_STAGES-1:0] out_state
);

  localparam int N_MODES = 2;

  logic [N_STAGES-1:0] state;
  logic [N_STAGES-1:0] seed;
  logic                load;
  logic                shift;
  logic [N_MODES-1:0]  fb_vec;
  logic                fb;

  seqgen_ctrl #(
    .N        (N_STAGES),
    .SEED_LIN (LIN_SEED),
    .SEED_NL  (NL_SEED)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .mode_nl   (mode_nl),
    .out_ready (out_ready),
    .state     (state),
    .load      (load),
    .seed      (seed),
    .shift     (shift),
    .valid     (out_valid)
  );

  for (genvar v = 0; v < N_MODES; v++) begin : g_fb
    seqgen_fb #(
      .N         (N_STAGES),
      .NONLINEAR (v == int'(MODE_NL)),
      .TAPS      (LIN_TAPS)
    ) u_fb (
      .state (state),
      .fb    (fb_vec[v])
    );
  end

  always_comb fb = fb_vec[mode_nl];

  seqgen_shreg #(
    .N (N_STAGES)
  ) u_shreg (
    .clk   (clk),
    .load  (load),
    .seed  (seed),
    .shift (shift),
    .fb    (fb),
    .state (state)
  );

  assign out_state = state;
  assign out_bit   = state[N_STAGES-1];

endmodule

// File: rtl/seqgen_chk.sv
module seqgen_chk
  import seqgen_pkg::*;
#(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic         mode_nl,
  input logic         out_ready,
  input logic         out_valid,
  input logic [N-1:0] out_state
);

  logic mode_seen;

  always_ff @(posedge clk) begin
    mode_seen <= mode_nl;
  end

  assert_seed_load_R1: assert property (@(posedge clk)
    rst |=> out_state == ($past(mode_nl) ? NL_SEED : LIN_SEED));

  assert_quiet_in_reset_R1: assert property (@(posedge clk)
    rst |-> !out_valid);

  assert_shift_toward_out_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |=> out_state[N-1:1] == $past(out_state[N-2:0]));

  assert_lin_feedback_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !mode_nl) |=>
      out_state[0] == ($past(out_state[N-1]) ^ $past(out_state[0])));

  assert_nl_feedback_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && mode_nl) |=>
      out_state[0] == !($past(out_state[N-1]) && $past(out_state[0]) &&
                        ($past(out_state[N-2]) || !$past(out_state[N-3]))));

  assert_valid_needs_en_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> en);

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!en && mode_nl == mode_seen && out_state != '0) |=> $stable(out_state));

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> $stable(out_state));

  assert_mode_gap_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> mode_nl == mode_seen);

  assert_mode_reload_R8: assert property (@(posedge clk) disable iff (rst)
    (mode_nl != mode_seen) |=> out_state == ($past(mode_nl) ? NL_SEED : LIN_SEED));

  assert_no_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !mode_nl) |-> out_state != '0);

  assert_nl_on_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && mode_nl) |->
      out_state inside {4'b1011, 4'b0111, 4'b1111, 4'b1110, 4'b1101, 4'b1010, 4'b0101});

endmodule

bind seqgen_top seqgen_chk #(.N(N_STAGES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .mode_nl   (mode_nl),
  .out_ready (out_ready),
  .out_valid (out_valid),
  .out_state (out_state)
);

// File: tb/sim_seqgen_top.sv
module sim_seqgen_top;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       mode_nl = 1'b0;
  logic       out_ready = 1'b0;
  logic       out_valid;
  logic       out_bit;
  logic [3:0] out_state;

  seqgen_top u0 (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .mode_nl   (mode_nl),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_bit   (out_bit),
    .out_state (out_state)
  );

  int    n_checks = 0;
  int    n_fails  = 0;
  bit    finished = 1'b0;
  string lin_str  = "111101011001000";
  string nl_str   = "1011110";

  // Reference: current mode and index of the bit at the output stage.
  bit m_mode = 1'b0;
  int m_k    = 0;

  function automatic bit ref_bit(bit m, int i);
    string s;
    s = m ? nl_str : lin_str;
    return s.getc(i % s.len()) == 8'h31;
  endfunction

  function automatic logic [3:0] ref_state(bit m, int k);
    return {ref_bit(m, k), ref_bit(m, k + 1), ref_bit(m, k + 2), ref_bit(m, k + 3)};
  endfunction

  function automatic int ref_len(bit m);
    return m ? nl_str.len() : lin_str.len();
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Inputs are set by the caller shortly after a rising edge.
  task automatic cycle(string req);
    logic       exp_v;
    logic       accept;
    logic [3:0] prev;
    #1;
    exp_v = en && !rst && (mode_nl == m_mode);
    if (!rst) begin
      check(req, "out_valid", 32'(out_valid), 32'(exp_v));
      check(req, "out_state", 32'(out_state), 32'(ref_state(m_mode, m_k)));
      check(req, "out_bit", 32'(out_bit), 32'(ref_bit(m_mode, m_k)));
      if (!m_mode && exp_v) check("R9", "nonzero state", 32'(out_state != 4'b0), 32'd1);
    end else begin
      check("R1", "out_valid in reset", 32'(out_valid), 32'd0);
    end
    accept = exp_v && out_ready;
    prev   = out_state;
    @(posedge clk);
    #1;
    if (rst || mode_nl != m_mode) begin
      m_mode = mode_nl;
      m_k    = 0;
    end else if (accept) begin
      m_k = (m_k + 1) % ref_len(m_mode);
    end
    if (accept && !rst) begin
      check("R4", "shift", 32'(out_state[3:1]), 32'(prev[2:0]));
      if (m_mode)
        check("R5", "nl feedback", 32'(out_state[0]),
              32'(!(prev[3] && prev[0] && (prev[2] || !prev[1]))));
      else
        check("R5", "lin feedback", 32'(out_state[0]), 32'(prev[3] ^ prev[0]));
    end
  endtask

  initial begin
    bit [15:0] seen;
    #1;
    rst = 1'b1; mode_nl = 1'b0; en = 1'b0; out_ready = 1'b0;
    repeat (2) cycle("R1");
    rst = 1'b0;
    cycle("R1");
    en = 1'b1; out_ready = 1'b1;
    repeat (30) cycle("R2");
    for (int i = 0; i < 12; i++) begin
      out_ready = (i % 3) != 0;
      cycle("R7");
    end
    out_ready = 1'b1; en = 1'b0;
    repeat (5) cycle("R6");
    en = 1'b1;
    repeat (8) cycle("R6");
    mode_nl = 1'b1;
    cycle("R8");
    seen = '0;
    for (int i = 0; i < 7; i++) begin
      seen[out_state] = 1'b1;
      cycle("R3");
    end
    check("R10", "distinct nl states", 32'($countones(seen)), 32'd7);
    repeat (7) cycle("R3");
    out_ready = 1'b0;
    repeat (3) cycle("R7");
    out_ready = 1'b1;
    repeat (3) cycle("R3");
    rst = 1'b1;
    cycle("R1");
    rst = 1'b0;
    cycle("R1");
    repeat (4) cycle("R3");
    en = 1'b0; mode_nl = 1'b0;
    cycle("R8");
    repeat (2) cycle("R8");
    en = 1'b1;
    repeat (32) cycle("R2");
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_fails++;
      $display("FAIL R1..all watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule